// File: doc/BRIEF.md
# Debug Breakpoint Match Unit

This block is the hardware breakpoint comparator inside a small microcontroller's debug engine. It keeps six 16-bit breakpoint values. It compares them every cycle against three kinds of CPU activity. The first kind is the instruction-fetch address. The second is the data-memory access address. The third is the identifier of a register being accessed. When a comparison hits and debugging is enabled, the block raises a one-cycle break request. The debug state machine uses that request to take the CPU into debug mode.

Slots 0 to 3 watch program fetches only. Slots 4 and 5 each have a mode bit, and that bit decides what the slot watches. With the bit at 0 the slot watches data-memory addresses. With the bit at 1 it watches register-access identifiers. The values and mode bits sit behind a small debug-side port that the CPU cannot reach. Both power-on reset and a TAP test-logic-reset put every value back to all-ones.

Top module: `brk_match_unit`

## Requirements
- R1: After power-on reset (`rst_n` low), all six breakpoint slots read 16'hFFFF and the mode word (select 6) reads 0. A valid fetch of address 16'hFFFF with `dbg_en` high therefore produces a break.
- R2: While `tap_tlr` is high at a clock edge, all slots return to 16'hFFFF and both mode bits return to 0. This has priority over a debug write in the same cycle.
- R3: A write (`dbg_wr` high) with `dbg_sel` 0..5 stores `dbg_wdata` in that slot. With `dbg_sel` = 6, bit 0 sets the mode of slot 4 and bit 1 sets the mode of slot 5. `dbg_rdata` returns the selected slot combinationally. Select 6 reads the mode bits in [1:0] with zeros above. Select 7 reads 0, and writes to select 7 change nothing.
- R4: Slots 0..3 hit only when `if_valid` is high and `if_addr` equals the slot value. Data and register-access events never make them hit.
- R5: A slot among 4..5 with mode 0 hits only when `da_valid` is high and `da_addr` equals its value. Register-access events are ignored by it.
- R6: A slot among 4..5 with mode 1 hits only when `ra_valid` is high and `ra_id` equals its value. Data-address events are ignored by it.
- R7: With `dbg_en` low, `brk_req` never asserts, whatever hits occur.
- R8: `brk_req` is registered. It is high in the cycle after each cycle that has a hit while `dbg_en` is high and `cpu_in_dbg` is low. A single hitting cycle gives exactly one cycle of `brk_req`.
- R9: While `cpu_in_dbg` is high, a hit does not produce `brk_req` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| tap_tlr | input | 1 | TAP in test-logic-reset, synchronous restore of all slots |
| dbg_sel | input | 3 | Debug port select: 0..5 slots, 6 mode word |
| dbg_wr | input | 1 | Debug port write strobe |
| dbg_wdata | input | 16 | Debug port write data |
| dbg_rdata | output | 16 | Debug port read data of the selected entry |
| dbg_en | input | 1 | Debug-mode enable; breaks are produced only when high |
| cpu_in_dbg | input | 1 | CPU already in debug mode |
| if_valid | input | 1 | Instruction fetch valid |
| if_addr | input | 16 | Program execution address |
| da_valid | input | 1 | Data-memory access valid |
| da_addr | input | 16 | Data-memory access address |
| ra_valid | input | 1 | Register-access strobe |
| ra_id | input | 16 | Identifier of the accessed register |
| brk_req | output | 1 | One-cycle break request |

## Verification
Several rules are checked by assertions on every cycle. A break request must trace back to an enabled hit from the previous cycle that occurred outside debug mode. Each program-slot hit must carry a fetch strobe, and each switchable-slot hit must carry the strobe of its selected mode. Test-logic-reset must leave every slot at all-ones, and a write must land in the addressed slot. Some behaviour only the bench scenarios can show. These include the read-back data path, the silent select 7, and the fact that the other mode's traffic is ignored. They also include the reset-value fetch break and the exact pulse count for single and back-to-back hits.

// File: rtl/brk_pkg.sv
package brk_pkg;
    // slot geometry
    localparam int BP_W     = 16;
    localparam int NUM_BP   = 6;
    localparam int NUM_PROG = 4;
    localparam int NUM_SW   = NUM_BP - NUM_PROG;
    localparam int SEL_W    = $clog2(NUM_BP + 2);
    localparam int MODE_SEL = NUM_BP;

    // mode encoding of switchable slots
    typedef enum logic {
        MODE_DATA = 1'b0,
        MODE_REG  = 1'b1
    } sw_mode_e;

    typedef logic [NUM_BP-1:0][BP_W-1:0] bp_vec_t;

    typedef struct packed {
        bp_vec_t           bp;
        logic [NUM_SW-1:0] mode;
    } slot_state_t;

    typedef struct packed {
        logic req;
    } req_state_t;
endpackage

// File: rtl/brk_regfile.sv
module brk_regfile
    import brk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tap_tlr,
    input  logic [SEL_W-1:0] sel,
    input  logic             wr,
    input  logic [BP_W-1:0]  wdata,
    output logic [BP_W-1:0]  rdata,
    output bp_vec_t          bp_o,
    output logic [NUM_SW-1:0] mode_o
);
    slot_state_t st_d, st_q;

    // next-state
    always_comb begin
        st_d = st_q;
        if (tap_tlr) begin
            st_d.bp   = '1;
            st_d.mode = '0;
        end else if (wr) begin
            for (int i = 0; i < NUM_BP; i++) begin
                if (sel == SEL_W'(i)) st_d.bp[i] = wdata;
            end
            if (sel == SEL_W'(MODE_SEL)) st_d.mode = wdata[NUM_SW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bp   <= '1;
            st_q.mode <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // read-back mux
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_BP; i++) begin
            if (sel == SEL_W'(i)) rdata = st_q.bp[i];
        end
        if (sel == SEL_W'(MODE_SEL)) rdata[NUM_SW-1:0] = st_q.mode;
    end

    assign bp_o   = st_q.bp;
    assign mode_o = st_q.mode;

    // R2: test-logic-reset restores every slot
    p_tlr_restore_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tap_tlr |=> ((&bp_o) && (mode_o == '0)));

    // R3: a write lands in the addressed slot
    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !tap_tlr && (sel < SEL_W'(NUM_BP))) |=> (bp_o[$past(sel)] == $past(wdata)));
endmodule

// File: rtl/brk_cmp.sv
module brk_cmp
    import brk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  bp_vec_t           bp,
    input  logic [NUM_SW-1:0] mode,
    input  logic              if_valid,
    input  logic [BP_W-1:0]   if_addr,
    input  logic              da_valid,
    input  logic [BP_W-1:0]   da_addr,
    input  logic              ra_valid,
    input  logic [BP_W-1:0]   ra_id,
    output logic [NUM_BP-1:0] hit
);
    for (genvar g = 0; g < NUM_BP; g++) begin : g_slot
        if (g < NUM_PROG) begin : g_prog
            assign hit[g] = if_valid && (if_addr == bp[g]);

            // R4: program slot hit only on a fetch
            p_prog_fetch_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
                hit[g] |-> (if_valid && (if_addr == bp[g])));
        end else begin : g_sw
            sw_mode_e m;
            assign m = sw_mode_e'(mode[g-NUM_PROG]);
            always_comb begin
                unique case (m)
                    MODE_DATA: hit[g] = da_valid && (da_addr == bp[g]);
                    MODE_REG:  hit[g] = ra_valid && (ra_id == bp[g]);
                    default:   hit[g] = 1'b0;
                endcase
            end

            // R5/R6: switchable hit carries the strobe of its mode
            p_sw_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (hit[g] && m == MODE_DATA) |-> da_valid);
            p_sw_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (hit[g] && m == MODE_REG) |-> ra_valid);
        end
    end
endmodule

// File: rtl/brk_req_gen.sv
module brk_req_gen
    import brk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_BP-1:0] hit,
    input  logic              dbg_en,
    input  logic              cpu_in_dbg,
    output logic              brk_req
);
    req_state_t rs_d, rs_q;

    always_comb begin
        rs_d     = rs_q;
        rs_d.req = (|hit) && dbg_en && !cpu_in_dbg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign brk_req = rs_q.req;

    // R7: no request without enable in the previous cycle
    p_req_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> $past(dbg_en));
    // R9: no request after a cycle spent in debug mode
    p_req_not_in_dbg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> !$past(cpu_in_dbg));
    // R8: every request traces back to a hit
    p_req_from_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> $past(|hit));
endmodule

// File: rtl/brk_match_unit.sv
module brk_match_unit
    import brk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tap_tlr,
    input  logic [2:0]       dbg_sel,
    input  logic             dbg_wr,
    input  logic [15:0]      dbg_wdata,
    output logic [15:0]      dbg_rdata,
    input  logic             dbg_en,
    input  logic             cpu_in_dbg,
    input  logic             if_valid,
    input  logic [15:0]      if_addr,
    input  logic             da_valid,
    input  logic [15:0]      da_addr,
    input  logic             ra_valid,
    input  logic [15:0]      ra_id,
    output logic             brk_req
);
    bp_vec_t           bp;
    logic [NUM_SW-1:0] mode;
    logic [NUM_BP-1:0] hit;

    brk_regfile i_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .tap_tlr(tap_tlr),
        .sel    (dbg_sel),
        .wr     (dbg_wr),
        .wdata  (dbg_wdata),
        .rdata  (dbg_rdata),
        .bp_o   (bp),
        .mode_o (mode)
    );

    brk_cmp i_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .bp      (bp),
        .mode    (mode),
        .if_valid(if_valid),
        .if_addr (if_addr),
        .da_valid(da_valid),
        .da_addr (da_addr),
        .ra_valid(ra_valid),
        .ra_id   (ra_id),
        .hit     (hit)
    );

    brk_req_gen i_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .dbg_en    (dbg_en),
        .cpu_in_dbg(cpu_in_dbg),
        .brk_req   (brk_req)
    );

    // R8: an enabled hit outside debug mode is answered next cycle
    p_hit_answered_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((|hit) && dbg_en && !cpu_in_dbg) |=> brk_req);
endmodule

// File: tb/test_brk_match_unit.sv
module test_brk_match_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tap_tlr = 1'b0;
    logic [2:0]  dbg_sel = '0;
    logic        dbg_wr = 1'b0;
    logic [15:0] dbg_wdata = '0;
    logic [15:0] dbg_rdata;
    logic        dbg_en = 1'b0;
    logic        cpu_in_dbg = 1'b0;
    logic        if_valid = 1'b0;
    logic [15:0] if_addr = '0;
    logic        da_valid = 1'b0;
    logic [15:0] da_addr = '0;
    logic        ra_valid = 1'b0;
    logic [15:0] ra_id = '0;
    logic        brk_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    brk_match_unit i_brk_match_unit (
        .clk(clk), .rst_n(rst_n), .tap_tlr(tap_tlr),
        .dbg_sel(dbg_sel), .dbg_wr(dbg_wr), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
        .dbg_en(dbg_en), .cpu_in_dbg(cpu_in_dbg),
        .if_valid(if_valid), .if_addr(if_addr),
        .da_valid(da_valid), .da_addr(da_addr),
        .ra_valid(ra_valid), .ra_id(ra_id),
        .brk_req(brk_req)
    );

    typedef struct packed {
        logic        ifv;
        logic [15:0] ifa;
        logic        dav;
        logic [15:0] daa;
        logic        rav;
        logic [15:0] rai;
        logic        en;
        logic        indbg;
        logic        exp;
    } vec_t;

    // slots: 0=1000 1=2000 2=3000 3=4000 4=5000(data) 5=6000(reg)
    localparam vec_t VECS [12] = '{
        '{1'b1, 16'h1000, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1}, // R4
        '{1'b1, 16'h4000, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1}, // R4
        '{1'b1, 16'h1001, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0}, // R4
        '{1'b0, 16'h1000, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0}, // R4
        '{1'b0, 16'h0000, 1'b1, 16'h5000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1}, // R5
        '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 16'h5000, 1'b1, 1'b0, 1'b0}, // R5
        '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 16'h6000, 1'b1, 1'b0, 1'b1}, // R6
        '{1'b0, 16'h0000, 1'b1, 16'h6000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0}, // R6
        '{1'b0, 16'h0000, 1'b1, 16'h1000, 1'b1, 16'h2000, 1'b1, 1'b0, 1'b0}, // R4
        '{1'b1, 16'h2000, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0}, // R7
        '{1'b1, 16'h3000, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0}, // R9
        '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0}  // R8
    };

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle();
        if_valid = 0; da_valid = 0; ra_valid = 0;
    endtask

    task automatic wr(input logic [2:0] s, input logic [15:0] d);
        @(negedge clk);
        dbg_sel = s; dbg_wdata = d; dbg_wr = 1;
        @(negedge clk);
        dbg_wr = 0;
    endtask

    task automatic rd_check(input string tag, input logic [2:0] s, input logic [15:0] exp);
        @(negedge clk);
        dbg_sel = s;
        #1;
        check(tag, dbg_rdata, exp);
    endtask

    // one cycle of stimulus, result sampled after the next edge
    task automatic step(input vec_t v, input string tag);
        @(negedge clk);
        if_valid = v.ifv; if_addr = v.ifa;
        da_valid = v.dav; da_addr = v.daa;
        ra_valid = v.rav; ra_id = v.rai;
        dbg_en = v.en; cpu_in_dbg = v.indbg;
        @(posedge clk);
        #2;
        check(tag, {15'd0, brk_req}, {15'd0, v.exp});
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset values
        for (int i = 0; i < 6; i++) rd_check("R1 slot reset", 3'(i), 16'hFFFF);
        rd_check("R1 mode reset", 3'd6, 16'h0000);
        check("R1 idle req", {15'd0, brk_req}, 16'h0000);
        step('{1'b1, 16'hFFFF, 1'b0, 16'h0, 1'b0, 16'h0, 1'b1, 1'b0, 1'b1}, "R1 fetch FFFF");
        @(negedge clk); idle(); dbg_en = 0;

        // R3 configure and read back
        wr(3'd0, 16'h1000); wr(3'd1, 16'h2000); wr(3'd2, 16'h3000);
        wr(3'd3, 16'h4000); wr(3'd4, 16'h5000); wr(3'd5, 16'h6000);
        wr(3'd6, 16'hFFFE);
        rd_check("R3 slot0", 3'd0, 16'h1000);
        rd_check("R3 slot3", 3'd3, 16'h4000);
        rd_check("R3 slot5", 3'd5, 16'h6000);
        rd_check("R3 mode word", 3'd6, 16'h0002);
        wr(3'd7, 16'hABCD);
        rd_check("R3 sel7 reads zero", 3'd7, 16'h0000);
        rd_check("R3 sel7 write ignored slot0", 3'd0, 16'h1000);
        rd_check("R3 sel7 write ignored mode", 3'd6, 16'h0002);

        // table walk
        foreach (VECS[i]) step(VECS[i], $sformatf("vector %0d", i));
        @(negedge clk); idle();

        // R8 single hit gives exactly one pulse
        step('{1'b1, 16'h2000, 1'b0, 16'h0, 1'b0, 16'h0, 1'b1, 1'b0, 1'b1}, "R8 single hit");
        step('{1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 16'h0, 1'b1, 1'b0, 1'b0}, "R8 pulse ends");
        // R8 back-to-back hits
        step('{1'b1, 16'h3000, 1'b0, 16'h0, 1'b0, 16'h0, 1'b1, 1'b0, 1'b1}, "R8 b2b first");
        step('{1'b0, 16'h0, 1'b1, 16'h5000, 1'b0, 16'h0, 1'b1, 1'b0, 1'b1}, "R8 b2b second");
        step('{1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 16'h0, 1'b1, 1'b0, 1'b0}, "R8 b2b end");

        // R6 mode swap: slot4 to register mode, slot5 to data mode
        wr(3'd6, 16'h0001);
        step('{1'b0, 16'h0, 1'b1, 16'h5000, 1'b0, 16'h0, 1'b1, 1'b0, 1'b0}, "R6 slot4 ignores data");
        step('{1'b0, 16'h0, 1'b0, 16'h0, 1'b1, 16'h5000, 1'b1, 1'b0, 1'b1}, "R6 slot4 reg hit");
        step('{1'b0, 16'h0, 1'b1, 16'h6000, 1'b0, 16'h0, 1'b1, 1'b0, 1'b1}, "R5 slot5 data hit");
        @(negedge clk); idle();

        // R2 test-logic-reset beats a concurrent write
        @(negedge clk);
        tap_tlr = 1; dbg_wr = 1; dbg_sel = 3'd2; dbg_wdata = 16'h1234;
        @(negedge clk);
        tap_tlr = 0; dbg_wr = 0;
        rd_check("R2 slot2", 3'd2, 16'hFFFF);
        rd_check("R2 slot4", 3'd4, 16'hFFFF);
        rd_check("R2 mode", 3'd6, 16'h0000);
        step('{1'b0, 16'h0, 1'b1, 16'hFFFF, 1'b0, 16'h0, 1'b1, 1'b0, 1'b1}, "R2 data mode restored");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule